// File: doc/BRIEF.md
# TDM Time-Slot Assigner

This block connects one channel of a voice processor to a serial time-division-multiplexed line. The line has a data clock, an 8 kHz frame sync, a serial input and an output that can be switched off. A bit counter starts at each frame sync. Two slot matchers use that counter to find the programmed input slot and the programmed output slot. Bits in the input slot are collected into a parallel word, which is then offered with a single-cycle valid strobe. A parallel word from the processing core is shifted out during the output slot.

Slot sizes follow the channel direction. A compressing channel takes byte-wide PCM slots in and sends nibble-wide code slots out. An expanding channel does the opposite. The number of slots in a frame depends on the slot width and on the companding law. Bypass loops the captured data straight back out without processing. Idle silences the channel. A strap-style mode pins both slots to slot 0. The line signals are brought into the fast system clock through synchronisers, and the data-clock edges become single-cycle strobes.

Top module: `tdm_slot_assigner`

## Requirements
- R1: While `rst` is high and right after it, `sdout_oe`, `sdout` and `rx_valid` are all 0.
- R2: A data-clock rising edge that finds `fsync` high starts bit 0 of a frame. Each later rising edge starts the next bit. Bit k of slot s, where the slot is w bits wide, is frame bit s*w+k. Input bits are sampled on falling edges. Output bits change only after rising edges.
- R3: Slot width is 8 for the input and 4 for the output when `cfg_compress`=1. It is 4 for the input and 8 for the output when `cfg_compress`=0.
- R4: The slot count per frame is set by parameters. With `cfg_mulaw`=1 the defaults are 32 byte slots and 64 nibble slots. The A-law counts (`cfg_mulaw`=0) are separate parameters.
- R5: Captured bits are shifted in MSB first. After the falling edge of the slot's last bit, `rx_word` holds the byte, or the nibble zero-extended in bits [3:0], and `rx_valid` is high for exactly one clock.
- R6: During the output slot, `sdout_oe` is 1 and `sdout` sends the source MSB first. The source is `tx_word` for a byte slot and `tx_word[3:0]` for a nibble slot. Outside the slot, `sdout_oe` and `sdout` are 0.
- R7: A slot number equal to or above the frame's slot count for its width never matches. Nothing is captured for it and nothing is driven for it.
- R8: With `cfg_idle`=1, `sdout_oe` stays 0 and `rx_valid` never fires.
- R9: With `cfg_bypass`=1 and `cfg_idle`=0, both directions use the input width. The output sends the most recently captured word in place of `tx_word`.
- R10: With `cfg_hwmode`=1, both the input and the output slot are 0, whatever `cfg_in_slot` and `cfg_out_slot` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the data clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Line data clock |
| fsync | input | 1 | Line frame sync |
| sdin | input | 1 | Serial line input |
| cfg_compress | input | 1 | 1 = compress direction, 0 = expand |
| cfg_mulaw | input | 1 | 1 = mu-law frame layout, 0 = A-law |
| cfg_bypass | input | 1 | Loop captured data back out unchanged |
| cfg_idle | input | 1 | Disable the channel |
| cfg_hwmode | input | 1 | Force both slots to 0 |
| cfg_in_slot | input | SLOT_W | Input slot number |
| cfg_out_slot | input | SLOT_W | Output slot number |
| tx_word | input | 8 | Parallel word to send in the output slot |
| rx_word | output | 8 | Last captured input word |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_word` |
| sdout | output | 1 | Serial line output data |
| sdout_oe | output | 1 | Output enable for the line driver |

## Verification
The assertions assume that the configuration inputs stay fixed for the whole frame, from the frame sync onward, and that the data clock is slow enough for every edge to pass through the synchronisers before the next edge. The bench changes configuration only between frames. It holds each data-clock phase for eight system clocks and drives `sdin` right after each rising edge, so the data is stable at every falling edge. Frame sync is raised before the rising edge of bit 0 and lowered before the falling edge that follows it.

// File: rtl/tsa_pkg.sv
`timescale 1ns/100ps
package tsa_pkg;

    localparam int BYTE_BITS = 8;
    localparam int NIB_BITS  = 4;

    // Direction and gating of one channel, derived from the control bits
    typedef struct packed {
        logic in_byte;   // input slot is byte wide
        logic out_byte;  // output slot is byte wide
        logic loop;      // bypass: send captured word
        logic quiet;     // idle
    } lane_mode_t;

    function automatic lane_mode_t decode_mode(logic compress, logic bypass, logic idle);
        lane_mode_t m;
        m.in_byte  = compress;
        m.out_byte = bypass ? compress : ~compress;
        m.loop     = bypass & ~idle;
        m.quiet    = idle;
        return m;
    endfunction

    function automatic int slot_limit(logic is_byte, logic mulaw,
                                      int mu_b, int mu_n, int a_b, int a_n);
        if (mulaw) return is_byte ? mu_b : mu_n;
        return is_byte ? a_b : a_n;
    endfunction

endpackage

// File: rtl/tsa_line_sync.sv
`timescale 1ns/100ps
module tsa_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dclk,
    input  logic fsync,
    input  logic sdin,
    output logic dclk_rise,
    output logic dclk_fall,
    output logic fsync_s,
    output logic sdin_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] dclk_q, fsync_q, sdin_q;
    logic              dclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_q    <= '0;
            fsync_q   <= '0;
            sdin_q    <= '0;
            dclk_prev <= 1'b0;
        end else begin
            dclk_q    <= {dclk_q[STAGES-2:0], dclk};
            fsync_q   <= {fsync_q[STAGES-2:0], fsync};
            sdin_q    <= {sdin_q[STAGES-2:0], sdin};
            dclk_prev <= dclk_q[LAST];
        end
    end

    assign dclk_rise = dclk_q[LAST] & ~dclk_prev;
    assign dclk_fall = ~dclk_q[LAST] & dclk_prev;
    assign fsync_s   = fsync_q[LAST];
    assign sdin_s    = sdin_q[LAST];

endmodule

// File: rtl/tsa_bit_timer.sv
`timescale 1ns/100ps
module tsa_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             frame_start,
    output logic [CNT_W-1:0] bitcnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Parked at CNT_MAX until a frame sync is seen; saturates there
    always_ff @(posedge clk) begin
        if (rst) begin
            bitcnt <= CNT_MAX;
        end else if (step) begin
            if (frame_start)
                bitcnt <= '0;
            else if (bitcnt != CNT_MAX)
                bitcnt <= bitcnt + 1'b1;
        end
    end

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (step && frame_start) |=> (bitcnt == '0)); // R2
    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && !frame_start && bitcnt != CNT_MAX) |=> (bitcnt == $past(bitcnt) + 1'b1)); // R2
    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(bitcnt)); // R2

endmodule

// File: rtl/tsa_slot_match.sv
`timescale 1ns/100ps
module tsa_slot_match #(
    parameter int CNT_W     = 10,
    parameter int SLOT_W    = 6,
    parameter bit WANT_LAST = 1'b0
) (
    input  logic [CNT_W-1:0]  bitcnt,
    input  logic              is_byte,
    input  logic [SLOT_W-1:0] slot,
    input  logic [SLOT_W:0]   limit,
    output logic              hit,
    output logic              edge_bit
);
    logic [CNT_W-1:0] idx;
    logic [2:0]       ofs;
    logic             in_range;

    always_comb begin
        idx      = is_byte ? (bitcnt >> 3) : (bitcnt >> 2);
        ofs      = is_byte ? bitcnt[2:0] : {1'b0, bitcnt[1:0]};
        in_range = ({1'b0, slot} < limit);
        hit      = in_range && (idx == CNT_W'(slot));
    end

    generate
        if (WANT_LAST) begin : g_last
            assign edge_bit = hit && (ofs == (is_byte ? 3'd7 : 3'd3));
        end else begin : g_first
            assign edge_bit = hit && (ofs == 3'd0);
        end
    endgenerate

endmodule

// File: rtl/tsa_rx.sv
`timescale 1ns/100ps
module tsa_rx (
    input  logic       clk,
    input  logic       rst,
    input  logic       fall,
    input  logic       sdin_s,
    input  logic       slot_hit,
    input  logic       slot_last,
    input  logic       in_byte,
    input  logic       idle,
    output logic [7:0] rx_word,
    output logic       rx_valid
);
    logic [6:0] sh;
    logic [7:0] nxt;

    assign nxt = {sh, sdin_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (fall && slot_hit && !idle) begin
                sh <= nxt[6:0];
                if (slot_last) begin
                    rx_word  <= in_byte ? nxt : {4'b0000, nxt[3:0]};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5
    AST_RX_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !$past(idle)); // R8
    AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word)); // R5

endmodule

// File: rtl/tsa_tx.sv
`timescale 1ns/100ps
module tsa_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  logic       slot_hit,
    input  logic       slot_first,
    input  logic       out_byte,
    input  logic       idle,
    input  logic [7:0] src,
    output logic       sdout,
    output logic       sdout_oe
);
    logic [7:0] sh;
    logic [7:0] load;
    logic       oe_q, sd_q;

    assign load = out_byte ? src : {src[3:0], 4'b0000};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            oe_q <= 1'b0;
            sd_q <= 1'b0;
        end else if (step) begin
            if (slot_hit && !idle) begin
                oe_q <= 1'b1;
                if (slot_first) begin
                    sd_q <= load[7];
                    sh   <= {load[6:0], 1'b0};
                end else begin
                    sd_q <= sh[7];
                    sh   <= {sh[6:0], 1'b0};
                end
            end else begin
                oe_q <= 1'b0;
                sd_q <= 1'b0;
            end
        end
    end

    assign sdout_oe = oe_q & ~idle;
    assign sdout    = sd_q & ~idle;

    AST_OE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) |-> $past(step)); // R2
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !oe_q |-> !sd_q); // R6

endmodule

// File: rtl/tdm_slot_assigner.sv
`timescale 1ns/100ps
module tdm_slot_assigner
    import tsa_pkg::*;
#(
    parameter int SLOT_W       = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int MU_BYTE_SLOTS = 32,
    parameter int MU_NIB_SLOTS  = 64,
    parameter int A_BYTE_SLOTS  = 32,
    parameter int A_NIB_SLOTS   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dclk,
    input  logic              fsync,
    input  logic              sdin,
    input  logic              cfg_compress,
    input  logic              cfg_mulaw,
    input  logic              cfg_bypass,
    input  logic              cfg_idle,
    input  logic              cfg_hwmode,
    input  logic [SLOT_W-1:0] cfg_in_slot,
    input  logic [SLOT_W-1:0] cfg_out_slot,
    input  logic [7:0]        tx_word,
    output logic [7:0]        rx_word,
    output logic              rx_valid,
    output logic              sdout,
    output logic              sdout_oe
);
    localparam int CNT_W = SLOT_W + 4;
    localparam int LIM_W = SLOT_W + 1;

    logic             rise, fall, fsync_s, sdin_s, rise_d;
    logic [CNT_W-1:0] bitcnt;
    lane_mode_t       mode;
    logic [SLOT_W-1:0] in_slot_eff, out_slot_eff;
    logic [LIM_W-1:0]  in_limit, out_limit;
    logic             in_hit, in_last, out_hit, out_first;
    logic [7:0]       tx_src;

    tsa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .sdin(sdin),
        .dclk_rise(rise), .dclk_fall(fall), .fsync_s(fsync_s), .sdin_s(sdin_s)
    );

    tsa_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .step(rise), .frame_start(fsync_s), .bitcnt(bitcnt)
    );

    // Output side acts one clock after the counter has moved to the new bit
    always_ff @(posedge clk) begin
        if (rst) rise_d <= 1'b0;
        else     rise_d <= rise;
    end

    always_comb begin
        mode         = decode_mode(cfg_compress, cfg_bypass, cfg_idle);
        in_slot_eff  = cfg_hwmode ? '0 : cfg_in_slot;
        out_slot_eff = cfg_hwmode ? '0 : cfg_out_slot;
        in_limit     = LIM_W'(slot_limit(mode.in_byte, cfg_mulaw, MU_BYTE_SLOTS,
                                         MU_NIB_SLOTS, A_BYTE_SLOTS, A_NIB_SLOTS));
        out_limit    = LIM_W'(slot_limit(mode.out_byte, cfg_mulaw, MU_BYTE_SLOTS,
                                         MU_NIB_SLOTS, A_BYTE_SLOTS, A_NIB_SLOTS));
        tx_src       = mode.loop ? rx_word : tx_word;
    end

    tsa_slot_match #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .WANT_LAST(1'b1)) u_in_match (
        .bitcnt(bitcnt), .is_byte(mode.in_byte), .slot(in_slot_eff),
        .limit(in_limit), .hit(in_hit), .edge_bit(in_last)
    );

    tsa_slot_match #(.CNT_W(CNT_W), .SLOT_W(SLOT_W), .WANT_LAST(1'b0)) u_out_match (
        .bitcnt(bitcnt), .is_byte(mode.out_byte), .slot(out_slot_eff),
        .limit(out_limit), .hit(out_hit), .edge_bit(out_first)
    );

    tsa_rx u_rx (
        .clk(clk), .rst(rst), .fall(fall), .sdin_s(sdin_s),
        .slot_hit(in_hit), .slot_last(in_last), .in_byte(mode.in_byte),
        .idle(mode.quiet), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    tsa_tx u_tx (
        .clk(clk), .rst(rst), .step(rise_d), .slot_hit(out_hit),
        .slot_first(out_first), .out_byte(mode.out_byte), .idle(mode.quiet),
        .src(tx_src), .sdout(sdout), .sdout_oe(sdout_oe)
    );

    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past({1'b0, in_slot_eff} < in_limit)); // R7
    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
        $rose(sdout_oe) |-> ({1'b0, out_slot_eff} < out_limit)); // R7
    AST_HW_CAPTURE_SLOT0: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && $past(cfg_hwmode) && $past(cfg_compress)) |-> ($past(bitcnt) == CNT_W'(7))); // R10

endmodule

// File: tb/sim_tdm_slot_assigner.sv
`timescale 1ns/100ps
module sim_tdm_slot_assigner;

    localparam int HALF = 8;
    localparam int FBITS = 256;
    localparam int AB = 24;
    localparam int AN = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dclk = 1'b0, fsync = 1'b0, sdin = 1'b0;
    logic cfg_compress = 1'b0, cfg_mulaw = 1'b1, cfg_bypass = 1'b0;
    logic cfg_idle = 1'b0, cfg_hwmode = 1'b0;
    logic [5:0] cfg_in_slot = '0, cfg_out_slot = '0;
    logic [7:0] tx_word = '0;
    logic [7:0] rx_word;
    logic rx_valid, sdout, sdout_oe;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = '0;
    logic obs_oe [FBITS];
    logic obs_d  [FBITS];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tdm_slot_assigner #(.A_BYTE_SLOTS(AB), .A_NIB_SLOTS(AN)) u0 (
        .clk(clk), .rst(rst), .dclk(dclk), .fsync(fsync), .sdin(sdin),
        .cfg_compress(cfg_compress), .cfg_mulaw(cfg_mulaw), .cfg_bypass(cfg_bypass),
        .cfg_idle(cfg_idle), .cfg_hwmode(cfg_hwmode), .cfg_in_slot(cfg_in_slot),
        .cfg_out_slot(cfg_out_slot), .tx_word(tx_word), .rx_word(rx_word),
        .rx_valid(rx_valid), .sdout(sdout), .sdout_oe(sdout_oe)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_word;
        end
    end

    function automatic logic [7:0] byte_at(int k, int seed);
        return 8'(k * 29 + seed);
    endfunction

    function automatic logic stream_bit(int b, int seed);
        logic [7:0] v;
        v = byte_at(b >> 3, seed);
        return v[7 - (b & 7)];
    endfunction

    function automatic int lim(bit is_byte, bit mu);
        if (mu) return is_byte ? 32 : 64;
        return is_byte ? AB : AN;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic run_frame(int seed);
        fsync = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < FBITS; b++) begin
            dclk = 1'b1;
            sdin = stream_bit(b, seed);
            repeat (HALF) @(negedge clk);
            if (b == 0) fsync = 1'b0;
            dclk = 1'b0;
            repeat (HALF) @(negedge clk);
            obs_oe[b] = sdout_oe;
            obs_d[b]  = sdout;
        end
        for (int e = 0; e < 2; e++) begin
            dclk = 1'b1;
            sdin = 1'b0;
            repeat (HALF) @(negedge clk);
            dclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic run_cfg(bit cp, bit mu, bit byp, bit idl, bit hw,
                           int ins, int outs, logic [7:0] tw, int seed, string tag);
        int iw, ow, is_, os_, c0, exp_cnt, oe_bad, d_bad, oe_n;
        bit in_ok, out_ok;
        logic [7:0] exp_rx, src;
        cfg_compress = cp; cfg_mulaw = mu; cfg_bypass = byp;
        cfg_idle = idl; cfg_hwmode = hw;
        cfg_in_slot = 6'(ins); cfg_out_slot = 6'(outs); tx_word = tw;
        if (byp) run_frame(seed);
        c0 = rx_cnt;
        run_frame(seed);
        repeat (2) @(negedge clk);
        iw  = cp ? 8 : 4;
        ow  = byp ? iw : (cp ? 4 : 8);
        is_ = hw ? 0 : ins;
        os_ = hw ? 0 : outs;
        in_ok  = !idl && (is_ < lim(iw == 8, mu));
        out_ok = !idl && (os_ < lim(ow == 8, mu));
        if (iw == 8) exp_rx = byte_at(is_, seed);
        else begin
            exp_rx = byte_at(is_ >> 1, seed);
            exp_rx = (is_ % 2 == 0) ? {4'b0, exp_rx[7:4]} : {4'b0, exp_rx[3:0]};
        end
        exp_cnt = in_ok ? 1 : 0;
        check(rx_cnt - c0 == exp_cnt, {tag, " capture count R5/R7"}, rx_cnt - c0, exp_cnt);
        if (in_ok)
            check(rx_last == exp_rx, {tag, " captured word R5 R3"}, int'(rx_last), int'(exp_rx));
        src = byp ? exp_rx : tw;
        if (ow == 4) src = {src[3:0], 4'b0};
        oe_bad = 0; d_bad = 0; oe_n = 0;
        for (int b = 0; b < FBITS; b++) begin
            bit want_oe;
            logic want_d;
            want_oe = out_ok && (b >= os_ * ow) && (b < os_ * ow + ow);
            want_d  = want_oe ? src[7 - (b - os_ * ow)] : 1'b0;
            if (obs_oe[b]) oe_n++;
            if (obs_oe[b] !== want_oe) oe_bad++;
            if (obs_d[b] !== want_d) d_bad++;
        end
        check(oe_bad == 0, {tag, " output enable window R6 R2"}, oe_n, out_ok ? ow : 0);
        check(d_bad == 0, {tag, " output data bits R6"}, d_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(sdout_oe == 1'b0 && sdout == 1'b0 && rx_valid == 1'b0, "R1 during reset",
              int'({sdout_oe, sdout, rx_valid}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sdout_oe == 1'b0 && sdout == 1'b0 && rx_valid == 1'b0, "R1 after reset",
              int'({sdout_oe, sdout, rx_valid}), 0);

        run_cfg(1, 1, 0, 0, 0,  0,  0, 8'hA5, 3,  "R3 cmp mu first");
        run_cfg(1, 1, 0, 0, 0, 31, 63, 8'h3C, 11, "R4 cmp mu last");
        run_cfg(1, 1, 0, 0, 0,  5, 17, 8'h96, 40, "R2 cmp mu mid");
        run_cfg(0, 1, 0, 0, 0, 63, 31, 8'hC3, 77, "R4 exp mu last");
        run_cfg(0, 1, 0, 0, 0, 10,  2, 8'h5A, 91, "R3 exp mu mid");
        run_cfg(1, 0, 0, 0, 0, 23, 47, 8'h71, 5,  "R4 cmp alaw last");
        run_cfg(1, 0, 0, 0, 0, 24, 48, 8'h71, 6,  "R7 cmp alaw beyond");
        run_cfg(0, 0, 0, 0, 0, 47, 23, 8'hE8, 8,  "R4 exp alaw last");
        run_cfg(0, 0, 0, 0, 0, 48, 24, 8'hE8, 9,  "R7 exp alaw beyond");
        run_cfg(1, 1, 0, 0, 0, 40,  2, 8'h1F, 13, "R7 cmp mu in beyond");
        run_cfg(1, 1, 1, 0, 0,  3,  9, 8'h00, 21, "R9 bypass byte");
        run_cfg(0, 1, 1, 0, 0,  7, 20, 8'hFF, 33, "R9 bypass nibble");
        run_cfg(1, 1, 1, 0, 0, 12,  4, 8'h00, 57, "R9 bypass out before in");
        run_cfg(1, 1, 0, 1, 0,  2,  2, 8'hAA, 60, "R8 idle");
        run_cfg(1, 1, 1, 1, 0,  2,  6, 8'hAA, 61, "R8 idle with bypass");
        run_cfg(1, 1, 0, 0, 1,  9,  9, 8'h4D, 70, "R10 hw cmp");
        run_cfg(0, 1, 0, 0, 1,  3,  5, 8'hB2, 71, "R10 hw exp");

        done = 1'b1;
        report();
        $finish;
    end

endmodule